// File: doc/BRIEF.md
# Associative Translation Buffer

This block caches a handful of recent virtual-page to physical-frame translations next to the CPU address path. A lookup presents a virtual page number and a page offset with a one-cycle strobe. The number is compared against every stored entry at once, so the search does not depend on where an entry sits. One cycle later the block reports either a hit, with the stored frame number, its access rights and the assembled physical address, or a miss. On a miss it hands the page number to the page-table walker.

When the walker finishes, it returns the translation through a refill port. The refill goes into a slot picked by a rotating pointer, unless that page is already cached, in which case the existing slot is rewritten. A flush strobe, raised on a context switch, empties the whole buffer in a single cycle.

Top module: `xlate_buffer`

## Requirements
- R1: After reset every entry is invalid and both `hitOut` and `missOut` are low, so the first lookup of any page number reports a miss.
- R2: A lookup strobe sampled at one rising edge raises exactly one of `hitOut` or `missOut` for the single cycle after that edge. On a hit, `hitPfn` carries the frame stored for the matching page number and `hitPerm` carries its rights. Both response outputs stay low in a cycle that follows an edge with no lookup.
- R3: On a miss, `missVpn` carries the page number of the lookup that missed, for the walker to fetch.
- R4: On a hit, `physAddr` equals the stored frame number in the upper bits, concatenated with the lookup's page offset, which is passed through unchanged.
- R5: A refill for a page number that is not cached writes into the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one after each such refill, wrapping from the last slot to slot 0. Once every slot is full, each new refill therefore evicts the oldest entry.
- R6: A refill for a page number that is already cached rewrites that entry's frame and rights in place, with no duplicate entry. The round-robin pointer does not move.
- R7: A flush invalidates every entry in one cycle. A lookup sampled in the same cycle as a flush reports a miss.
- R8: A refill sampled in the same cycle as a flush is discarded.
- R9: A lookup sampled in the same cycle as a refill is compared against the contents as they were before that refill.
- R10: `refillPerm` and `hitPerm` hold the rights as bit 2 read, bit 1 write and bit 0 execute. They are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup strobe |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupOffset | input | OFF_W | Page offset passed through to the physical address |
| flush | input | 1 | Invalidate all entries (context switch) |
| refillValid | input | 1 | Refill strobe from the walker |
| refillVpn | input | VPN_W | Page number of the refill |
| refillPfn | input | PFN_W | Frame number of the refill |
| refillPerm | input | 3 | Rights of the refill (read, write, execute) |
| hitOut | output | 1 | Lookup hit, one cycle after the strobe |
| missOut | output | 1 | Lookup miss / walk request, one cycle after the strobe |
| missVpn | output | VPN_W | Page number to walk |
| hitPfn | output | PFN_W | Frame number on a hit |
| hitPerm | output | 3 | Rights on a hit |
| physAddr | output | PFN_W+OFF_W | Frame number joined with the offset |

## Verification
The bench builds the block with four entries, 20-bit page and frame numbers and a 12-bit offset. With only four slots, a handful of refills wraps the rotating pointer and evicts the oldest translation. The same sequence also shows that an in-place rewrite leaves the pointer where it was, because the next new refill evicts the slot that the pointer already named. The 20-bit widths keep the page and frame values distinct from each other in every comparison.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int PERM_W = 3;

  typedef struct packed {
    logic lookupEn;
    logic flushAll;
    logic writeEn;
  } xlateStrobes_t;
endpackage

// File: rtl/xlate_data.sv
module xlate_data
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xlateStrobes_t          strb,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOffset,
  input  logic [VPN_W-1:0]       refillVpn,
  input  logic [PFN_W-1:0]       refillPfn,
  input  logic [PERM_W-1:0]      refillPerm,
  output logic [ENTRIES-1:0]     lookupMatch,
  output logic [ENTRIES-1:0]     refillMatch,
  output logic [PFN_W-1:0]       outPfn,
  output logic [PERM_W-1:0]      outPerm,
  output logic [PFN_W+OFF_W-1:0] outPhys
);
  logic [ENTRIES-1:0] validVec;
  logic [VPN_W-1:0]   vpnArr  [ENTRIES];
  logic [PFN_W-1:0]   pfnArr  [ENTRIES];
  logic [PERM_W-1:0]  permArr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic slotWrite;
    assign slotWrite      = strb.writeEn && (wrIdx == IDX_W'(i));
    assign lookupMatch[i] = validVec[i] && (vpnArr[i] == lookupVpn);
    assign refillMatch[i] = validVec[i] && (vpnArr[i] == refillVpn);

    always_ff @(posedge clk) begin
      if (!rstN)               validVec[i] <= 1'b0;
      else if (strb.flushAll)  validVec[i] <= 1'b0;
      else if (slotWrite)      validVec[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slotWrite) begin
        vpnArr[i]  <= refillVpn;
        pfnArr[i]  <= refillPfn;
        permArr[i] <= refillPerm;
      end
    end
  end

  logic [PFN_W-1:0]  selPfn;
  logic [PERM_W-1:0] selPerm;

  always_comb begin
    selPfn  = '0;
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupMatch[i]) begin
        selPfn  = selPfn  | pfnArr[i];
        selPerm = selPerm | permArr[i];
      end
    end
    if (strb.flushAll) begin
      selPfn  = '0;
      selPerm = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPfn  <= '0;
      outPerm <= '0;
      outPhys <= '0;
    end else if (strb.lookupEn) begin
      outPfn  <= selPfn;
      outPerm <= selPerm;
      outPhys <= {selPfn, lookupOffset};
    end
  end

  // R6: the in-place rewrite rule keeps page numbers unique
  p_unique_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupMatch));

  // R7: a flush leaves no valid entry behind
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validVec == '0));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic               flush,
  input  logic               refillValid,
  input  logic [ENTRIES-1:0] lookupMatch,
  input  logic [ENTRIES-1:0] refillMatch,
  output xlateStrobes_t      strb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               hitOut,
  output logic               missOut,
  output logic [VPN_W-1:0]   missVpn
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] dupIdx;
  logic             refillDup;
  logic             lookupHit;

  assign refillDup = |refillMatch;
  assign lookupHit = |lookupMatch;

  always_comb begin
    dupIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (refillMatch[i]) dupIdx = IDX_W'(i);
  end

  assign wrIdx         = refillDup ? dupIdx : rrPtr;
  assign strb.lookupEn = lookupValid;
  assign strb.flushAll = flush;
  assign strb.writeEn  = refillValid && !flush;

  always_ff @(posedge clk) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strb.writeEn && !refillDup)
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitOut  <= 1'b0;
      missOut <= 1'b0;
      missVpn <= '0;
    end else begin
      hitOut  <= lookupValid && !flush && lookupHit;
      missOut <= lookupValid && (flush || !lookupHit);
      if (lookupValid) missVpn <= lookupVpn;
    end
  end

  // R2: one response only, and only after a lookup
  p_single_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(hitOut && missOut));
  p_resp_after_lookup_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (hitOut || missOut));
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> (!hitOut && !missOut));
  // R3: walker receives the missing page number
  p_miss_vpn_r3: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!missOut || missVpn == $past(lookupVpn)));
  // R7: lookup alongside flush misses
  p_flush_lookup_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && flush) |=> missOut);
  // R5: new refill steps the pointer with wrap
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush && !refillDup) |=>
      (rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1)));
  // R6 / R8: rewrite or dropped refill keeps the pointer
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && (refillDup || flush)) |=> $stable(rrPtr));
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOffset,
  input  logic                   flush,
  input  logic                   refillValid,
  input  logic [VPN_W-1:0]       refillVpn,
  input  logic [PFN_W-1:0]       refillPfn,
  input  logic [2:0]             refillPerm,
  output logic                   hitOut,
  output logic                   missOut,
  output logic [VPN_W-1:0]       missVpn,
  output logic [PFN_W-1:0]       hitPfn,
  output logic [2:0]             hitPerm,
  output logic [PFN_W+OFF_W-1:0] physAddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xlateStrobes_t      strb;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] lookupMatch;
  logic [ENTRIES-1:0] refillMatch;

  xlate_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .flush(flush), .refillValid(refillValid), .lookupMatch(lookupMatch),
    .refillMatch(refillMatch), .strb(strb), .wrIdx(wrIdx),
    .hitOut(hitOut), .missOut(missOut), .missVpn(missVpn)
  );

  xlate_data #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
               .OFF_W(OFF_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx),
    .lookupVpn(lookupVpn), .lookupOffset(lookupOffset),
    .refillVpn(refillVpn), .refillPfn(refillPfn), .refillPerm(refillPerm),
    .lookupMatch(lookupMatch), .refillMatch(refillMatch),
    .outPfn(hitPfn), .outPerm(hitPerm), .outPhys(physAddr)
  );
endmodule

// File: tb/xlate_buffer_tb.sv
module xlate_buffer_tb;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 20;
  localparam int OFF_W   = 12;
  localparam int NVEC    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [VPN_W-1:0] lookupVpn = '0;
  logic [OFF_W-1:0] lookupOffset = '0;
  logic flush = 1'b0;
  logic refillValid = 1'b0;
  logic [VPN_W-1:0] refillVpn = '0;
  logic [PFN_W-1:0] refillPfn = '0;
  logic [2:0] refillPerm = '0;
  logic hitOut, missOut;
  logic [VPN_W-1:0] missVpn;
  logic [PFN_W-1:0] hitPfn;
  logic [2:0] hitPerm;
  logic [PFN_W+OFF_W-1:0] physAddr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  xlate_buffer #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupOffset(lookupOffset), .flush(flush), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillPfn(refillPfn), .refillPerm(refillPerm),
    .hitOut(hitOut), .missOut(missOut), .missVpn(missVpn), .hitPfn(hitPfn),
    .hitPerm(hitPerm), .physAddr(physAddr)
  );

  // op[45:44] 0 lookup, 1 refill, 2 flush; vpn[43:24]; pfn[23:4]; perm[3:1]; expHit[0]
  // lookup rows carry the expected frame and rights in the pfn/perm fields
  localparam logic [45:0] VEC [NVEC] = '{
    {2'd0, 20'h00010, 20'h00000, 3'd0, 1'b0},  // R1 first lookup misses
    {2'd1, 20'h00010, 20'hAAAAA, 3'd4, 1'b0},  // R5 slot0
    {2'd0, 20'h00010, 20'hAAAAA, 3'd4, 1'b1},  // R2 hit
    {2'd1, 20'h00020, 20'h12345, 3'd6, 1'b0},  // slot1
    {2'd1, 20'h00030, 20'h0F0F0, 3'd1, 1'b0},  // slot2
    {2'd1, 20'h00040, 20'h00001, 3'd7, 1'b0},  // slot3, pointer wraps
    {2'd0, 20'h00030, 20'h0F0F0, 3'd1, 1'b1},
    {2'd0, 20'h00040, 20'h00001, 3'd7, 1'b1},
    {2'd1, 20'h00050, 20'h55555, 3'd2, 1'b0},  // R5 evicts slot0
    {2'd0, 20'h00010, 20'h00000, 3'd0, 1'b0},  // R5 evicted page misses
    {2'd0, 20'h00050, 20'h55555, 3'd2, 1'b1},
    {2'd1, 20'h00020, 20'hBEEF0, 3'd5, 1'b0},  // R6 rewrite in place
    {2'd0, 20'h00020, 20'hBEEF0, 3'd5, 1'b1},
    {2'd1, 20'h00060, 20'h00777, 3'd3, 1'b0},  // R6 pointer held: lands in slot1
    {2'd0, 20'h00020, 20'h00000, 3'd0, 1'b0},
    {2'd0, 20'h00030, 20'h0F0F0, 3'd1, 1'b1},
    {2'd0, 20'h00060, 20'h00777, 3'd3, 1'b1},
    {2'd2, 20'h00000, 20'h00000, 3'd0, 1'b0},  // R7 flush
    {2'd0, 20'h00030, 20'h00000, 3'd0, 1'b0},
    {2'd0, 20'h00060, 20'h00000, 3'd0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, return at the next falling edge
  task automatic drive(input bit lv, input logic [VPN_W-1:0] lvpn,
                       input logic [OFF_W-1:0] loff, input bit fl, input bit rv,
                       input logic [VPN_W-1:0] rvpn, input logic [PFN_W-1:0] rpfn,
                       input logic [2:0] rperm);
    lookupValid = lv; lookupVpn = lvpn; lookupOffset = loff; flush = fl;
    refillValid = rv; refillVpn = rvpn; refillPfn = rpfn; refillPerm = rperm;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b0; refillValid = 1'b0;
  endtask

  task automatic expectMiss(input string tag, input logic [VPN_W-1:0] vpn);
    check(!hitOut && missOut, tag, {62'd0, hitOut, missOut}, 64'h1);
    check(missVpn == vpn, tag, 64'(missVpn), 64'(vpn));
  endtask

  task automatic expectHit(input string tag, input logic [PFN_W-1:0] pfn,
                           input logic [2:0] perm);
    check(hitOut && !missOut, tag, {62'd0, hitOut, missOut}, 64'h2);
    check(hitPfn == pfn, tag, 64'(hitPfn), 64'(pfn));
    check(hitPerm == perm, tag, 64'(hitPerm), 64'(perm));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in and right after reset
    check(!hitOut && !missOut, "R1", {62'd0, hitOut, missOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!hitOut && !missOut, "R1", {62'd0, hitOut, missOut}, 64'h0);

    for (int k = 0; k < NVEC; k++) begin
      logic [45:0] v;
      v = VEC[k];
      case (v[45:44])
        2'd0: begin
          drive(1'b1, v[43:24], '0, 1'b0, 1'b0, '0, '0, '0);
          if (v[0]) expectHit("R2", v[23:4], v[3:1]);
          else      expectMiss("R3", v[43:24]);
        end
        2'd1: drive(1'b0, '0, '0, 1'b0, 1'b1, v[43:24], v[23:4], v[3:1]);
        default: drive(1'b0, '0, '0, 1'b1, 1'b0, '0, '0, '0);
      endcase
    end

    // R4 and R10: physical address joins frame and offset; rights returned as stored
    drive(1'b0, '0, '0, 1'b0, 1'b1, 20'h00ABC, 20'h13579, 3'b100);
    drive(1'b1, 20'h00ABC, 12'hDEF, 1'b0, 1'b0, '0, '0, '0);
    expectHit("R10", 20'h13579, 3'b100);
    check(physAddr == {20'h13579, 12'hDEF}, "R4", 64'(physAddr), 64'h13579DEF);

    // R7: lookup together with flush misses, and the entry is gone afterwards
    drive(1'b1, 20'h00ABC, '0, 1'b1, 1'b0, '0, '0, '0);
    expectMiss("R7", 20'h00ABC);
    drive(1'b1, 20'h00ABC, '0, 1'b0, 1'b0, '0, '0, '0);
    expectMiss("R7", 20'h00ABC);

    // R8: refill in the flush cycle is dropped
    drive(1'b0, '0, '0, 1'b1, 1'b1, 20'h0CAFE, 20'h11111, 3'd7);
    drive(1'b1, 20'h0CAFE, '0, 1'b0, 1'b0, '0, '0, '0);
    expectMiss("R8", 20'h0CAFE);

    // R9: lookup in the refill cycle sees the old contents
    drive(1'b1, 20'h0D00D, '0, 1'b0, 1'b1, 20'h0D00D, 20'h24680, 3'd2);
    expectMiss("R9", 20'h0D00D);
    drive(1'b1, 20'h0D00D, '0, 1'b0, 1'b0, '0, '0, '0);
    expectHit("R9", 20'h24680, 3'd2);

    // R2: no lookup, no response
    drive(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, '0);
    check(!hitOut && !missOut, "R2", {62'd0, hitOut, missOut}, 64'h0);

    finishRun();
  end
endmodule